// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers hardware event pulses into three groups of sticky status bits and turns each group into one level-sensitive interrupt line. The main group has a 32-bit status register and a separate 32-bit enable mask. The DMA group packs its 16 status bits and their 16 enable bits into one 32-bit word. The mailbox flag group has 32 status bits and no mask.

Software clears status bits by writing ones to them. A one in the write data clears the matching bit, and a zero leaves it alone. Each group's interrupt output is a registered active-high level. It stays high for as long as any enabled status bit in that group is set. A register write takes effect on the clock edge where it is presented, so the outputs and the readback both change one cycle after the write. Reads are side-effect free and come back combinationally on `rd_data`. The DMA enable half cannot be changed through the bus word. It is loaded through its own strobe, so the mask can be set up without touching the DMA status bits.

Top module: `irq_status_hub`

## Requirements
- R1: After synchronous reset, every status bit and every mask bit is 0, and `main_irq`, `dma_irq` and `flag_irq` are all 0.
- R2: A one on a bit of `main_evt`, `dma_evt` or `flag_evt` at a clock edge sets the matching status bit. The bit reads back as 1 from the next cycle on and stays set until it is cleared.
- R3: A write to address 0xF000 clears each main status bit whose `wr_data` bit is 1 and leaves the other bits unchanged. A read of 0xF000 returns the main status.
- R4: Address 0xF010 holds the main mask, which is read/write in full. `main_irq` equals the OR of (main status AND main mask), and it reflects any write or event one cycle later.
- R5: Address 0xE010 reads as {DMA mask in bits [31:16], DMA status in bits [15:0]}. A write there clears each DMA status bit whose `wr_data[15:0]` bit is 1 and never changes the mask, whatever `wr_data[31:16]` holds.
- R6: When `dma_mask_we` is 1 at a clock edge, the DMA mask is loaded from `dma_mask_in` and the DMA status bits are not changed.
- R7: `dma_irq` equals the OR of (DMA status AND DMA mask), registered with the same one-cycle timing as in R4.
- R8: Address 0xF230 holds the mailbox flags and is write-one-to-clear. `flag_irq` is 1 exactly when any flag bit is set, with the same timing as in R4.
- R9: When an event pulse and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R10: A write to any other address changes no register. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | 16 | Byte offset of the write |
| wr_data | input | 32 | Write data (ones clear status bits) |
| rd_addr | input | 16 | Byte offset of the read |
| rd_data | output | 32 | Combinational read data |
| main_evt | input | 32 | Event pulses for the main status |
| dma_evt | input | 16 | Event pulses for the DMA status |
| flag_evt | input | 32 | Event pulses for the mailbox flags |
| dma_mask_we | input | 1 | Load strobe for the DMA mask half |
| dma_mask_in | input | 16 | New DMA mask value |
| main_irq | output | 1 | Main group interrupt level |
| dma_irq | output | 1 | DMA group interrupt level |
| flag_irq | output | 1 | Mailbox flag interrupt level |

## Verification
The hardest case to reach from the ports is the same edge carrying both an event and a clear for the same bit while a mask strobe changes the enable set. In that case the interrupt level depends on all three updates taken together. The random stimulus uses sparse event pulses and frequent writes whose data is often all ones, so these collisions occur many times. Directed steps also force the collision on a single chosen bit of each group. A further directed step writes all ones to the DMA word and checks that its mask half is unchanged.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    localparam logic [ADDR_W-1:0] OFS_MAIN_STAT = 16'hF000;
    localparam logic [ADDR_W-1:0] OFS_MAIN_MASK = 16'hF010;
    localparam logic [ADDR_W-1:0] OFS_DMA_WORD  = 16'hE010;
    localparam logic [ADDR_W-1:0] OFS_FLAGS     = 16'hF230;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MAIN_STAT,
        SEL_MAIN_MASK,
        SEL_DMA_WORD,
        SEL_FLAGS
    } reg_sel_e;

    typedef struct packed {
        logic main_stat;
        logic main_mask;
        logic dma_word;
        logic flags;
    } wr_hits_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        case (ofs)
            OFS_MAIN_STAT: return SEL_MAIN_STAT;
            OFS_MAIN_MASK: return SEL_MAIN_MASK;
            OFS_DMA_WORD:  return SEL_DMA_WORD;
            OFS_FLAGS:     return SEL_FLAGS;
            default:       return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irqh_decode.sv
module irqh_decode
    import irqh_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output wr_hits_t          hits,
    output reg_sel_e          rd_sel
);
    reg_sel_e wr_sel;

    always_comb begin
        wr_sel = decode_ofs(wr_addr);
        rd_sel = decode_ofs(rd_addr);
        hits.main_stat = wr_en && (wr_sel == SEL_MAIN_STAT);
        hits.main_mask = wr_en && (wr_sel == SEL_MAIN_MASK);
        hits.dma_word  = wr_en && (wr_sel == SEL_DMA_WORD);
        hits.flags     = wr_en && (wr_sel == SEL_FLAGS);
    end
endmodule

// File: rtl/irqh_w1c_reg.sv
module irqh_w1c_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);
    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we ? clr_i : '0;
        // event set takes priority over a same-edge clear
        nxt = (q & ~clr_eff) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/irqh_level_out.sv
module irqh_level_out #(
    parameter int  W        = 32,
    parameter bit  USE_MASK = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stat_nxt,
    input  logic [W-1:0] mask_nxt,
    output logic         irq
);
    logic pending;

    generate
        if (USE_MASK) begin : g_masked
            assign pending = |(stat_nxt & mask_nxt);
        end else begin : g_plain
            logic [W-1:0] unused_mask;
            assign unused_mask = mask_nxt;
            assign pending = |stat_nxt;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= pending;
    end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
    import irqh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] main_evt,
    input  logic [HALF_W-1:0] dma_evt,
    input  logic [DATA_W-1:0] flag_evt,
    input  logic              dma_mask_we,
    input  logic [HALF_W-1:0] dma_mask_in,
    output logic              main_irq,
    output logic              dma_irq,
    output logic              flag_irq
);
    wr_hits_t hits;
    reg_sel_e rd_sel;

    logic [DATA_W-1:0] main_stat, main_stat_nxt;
    logic [DATA_W-1:0] main_mask, main_mask_nxt;
    logic [HALF_W-1:0] dma_stat, dma_stat_nxt;
    logic [HALF_W-1:0] dma_mask, dma_mask_nxt;
    logic [DATA_W-1:0] flags, flags_nxt;

    irqh_decode u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .rd_addr(rd_addr),
        .hits   (hits),
        .rd_sel (rd_sel)
    );

    irqh_w1c_reg #(.W(DATA_W)) u_main (
        .clk(clk), .rst(rst), .set_i(main_evt),
        .clr_we(hits.main_stat), .clr_i(wr_data),
        .q(main_stat), .nxt(main_stat_nxt)
    );

    irqh_w1c_reg #(.W(HALF_W)) u_dma (
        .clk(clk), .rst(rst), .set_i(dma_evt),
        .clr_we(hits.dma_word), .clr_i(wr_data[HALF_W-1:0]),
        .q(dma_stat), .nxt(dma_stat_nxt)
    );

    irqh_w1c_reg #(.W(DATA_W)) u_flags (
        .clk(clk), .rst(rst), .set_i(flag_evt),
        .clr_we(hits.flags), .clr_i(wr_data),
        .q(flags), .nxt(flags_nxt)
    );

    // mask registers: main is plain read/write, DMA half only via strobe
    always_comb begin
        main_mask_nxt = hits.main_mask ? wr_data : main_mask;
        dma_mask_nxt  = dma_mask_we ? dma_mask_in : dma_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_mask <= '0;
            dma_mask  <= '0;
        end else begin
            main_mask <= main_mask_nxt;
            dma_mask  <= dma_mask_nxt;
        end
    end

    irqh_level_out #(.W(DATA_W), .USE_MASK(1'b1)) u_irq_main (
        .clk(clk), .rst(rst), .stat_nxt(main_stat_nxt),
        .mask_nxt(main_mask_nxt), .irq(main_irq)
    );

    irqh_level_out #(.W(HALF_W), .USE_MASK(1'b1)) u_irq_dma (
        .clk(clk), .rst(rst), .stat_nxt(dma_stat_nxt),
        .mask_nxt(dma_mask_nxt), .irq(dma_irq)
    );

    irqh_level_out #(.W(DATA_W), .USE_MASK(1'b0)) u_irq_flag (
        .clk(clk), .rst(rst), .stat_nxt(flags_nxt),
        .mask_nxt('0), .irq(flag_irq)
    );

    always_comb begin
        case (rd_sel)
            SEL_MAIN_STAT: rd_data = main_stat;
            SEL_MAIN_MASK: rd_data = main_mask;
            SEL_DMA_WORD:  rd_data = {dma_mask, dma_stat};
            SEL_FLAGS:     rd_data = flags;
            default:       rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irqh_checker.sv
module irqh_checker
    import irqh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] main_evt,
    input logic              dma_mask_we,
    input logic [DATA_W-1:0] main_stat,
    input logic [DATA_W-1:0] main_mask,
    input logic [HALF_W-1:0] dma_stat,
    input logic [HALF_W-1:0] dma_mask,
    input logic [DATA_W-1:0] flags,
    input logic              main_irq,
    input logic              dma_irq,
    input logic              flag_irq
);
    AST_MAIN_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|main_evt) |=> ((main_stat & $past(main_evt)) == $past(main_evt))); // R9

    AST_MAIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_MAIN_STAT && main_evt == '0) |=> ((main_stat & $past(wr_data)) == '0)); // R3

    AST_DMA_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_DMA_WORD && !dma_mask_we) |=> $stable(dma_mask)); // R5

    AST_MAIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
        main_irq == (|(main_stat & main_mask))); // R4

    AST_DMA_LEVEL: assert property (@(posedge clk) disable iff (rst)
        dma_irq == (|(dma_stat & dma_mask))); // R7

    AST_FLAG_LEVEL: assert property (@(posedge clk) disable iff (rst)
        flag_irq == (|flags)); // R8
endmodule

bind irq_status_hub irqh_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .main_evt(main_evt), .dma_mask_we(dma_mask_we),
    .main_stat(main_stat), .main_mask(main_mask),
    .dma_stat(dma_stat), .dma_mask(dma_mask), .flags(flags),
    .main_irq(main_irq), .dma_irq(dma_irq), .flag_irq(flag_irq)
);

// File: tb/tb_irq_status_hub.sv
`timescale 1ns/100ps
module tb_irq_status_hub;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [15:0] rd_addr;
    logic [31:0] rd_data;
    logic [31:0] main_evt;
    logic [15:0] dma_evt;
    logic [31:0] flag_evt;
    logic        dma_mask_we;
    logic [15:0] dma_mask_in;
    logic        main_irq, dma_irq, flag_irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] m_main, m_mmask, m_flag;
    logic [15:0] m_dst, m_dmk;

    always #2 clk = ~clk;

    irq_status_hub dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .main_evt(main_evt), .dma_evt(dma_evt),
        .flag_evt(flag_evt), .dma_mask_we(dma_mask_we), .dma_mask_in(dma_mask_in),
        .main_irq(main_irq), .dma_irq(dma_irq), .flag_irq(flag_irq)
    );

    function automatic logic [31:0] w1c(input logic [31:0] q, input bit hit,
                                        input logic [31:0] d, input logic [31:0] s);
        return (q & ~(hit ? d : 32'h0)) | s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        rd_addr = a;
        #0.2;
        check(req, rd_data, exp);
    endtask

    task automatic check_all();
        read_chk("R2 R3 main status", 16'hF000, m_main);
        read_chk("R4 main mask", 16'hF010, m_mmask);
        read_chk("R5 R6 dma word", 16'hE010, {m_dmk, m_dst});
        read_chk("R8 flags", 16'hF230, m_flag);
        check("R4 main_irq", {31'h0, main_irq}, {31'h0, |(m_main & m_mmask)});
        check("R7 dma_irq", {31'h0, dma_irq}, {31'h0, |(m_dst & m_dmk)});
        check("R8 flag_irq", {31'h0, flag_irq}, {31'h0, |m_flag});
    endtask

    // drive at negedge, update model, wait one edge, check at the next negedge
    task automatic step(input bit we, input logic [15:0] a, input logic [31:0] d,
                        input logic [31:0] me, input logic [15:0] de, input logic [31:0] fe,
                        input bit mwe, input logic [15:0] mi);
        wr_en = we; wr_addr = a; wr_data = d;
        main_evt = me; dma_evt = de; flag_evt = fe;
        dma_mask_we = mwe; dma_mask_in = mi;
        m_main = w1c(m_main, we && a == 16'hF000, d, me);
        if (we && a == 16'hF010) m_mmask = d;
        m_dst = w1c({16'h0, m_dst}, we && a == 16'hE010, {16'h0, d[15:0]}, {16'h0, de})
                & 32'h0000_FFFF;
        if (mwe) m_dmk = mi;
        m_flag = w1c(m_flag, we && a == 16'hF230, d, fe);
        @(negedge clk);
        wr_en = 1'b0; main_evt = '0; dma_evt = '0; flag_evt = '0; dma_mask_we = 1'b0;
        check_all();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        main_evt = 0; dma_evt = 0; flag_evt = 0; dma_mask_we = 0; dma_mask_in = 0;
        m_main = 0; m_mmask = 0; m_flag = 0; m_dst = 0; m_dmk = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all(); // R1 reset state

        // R2 events set bits
        step(0, 16'h0, 0, 32'h8000_0001, 16'h0003, 32'h0000_0100, 0, 0);
        // R4 mask enables main irq one cycle after write
        step(1, 16'hF010, 32'h0000_0001, 0, 0, 0, 0, 0);
        check("R4 irq up", {31'h0, main_irq}, 32'h1);
        // R3 clear one bit only
        step(1, 16'hF000, 32'h0000_0001, 0, 0, 0, 0, 0);
        check("R3 irq down", {31'h0, main_irq}, 32'h0);
        // R6 mask strobe, status untouched
        step(0, 16'h0, 0, 0, 0, 0, 1, 16'h0002);
        check("R6 dma_irq", {31'h0, dma_irq}, 32'h1);
        // R5 write all ones: status cleared, mask kept
        step(1, 16'hE010, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        read_chk("R5 mask kept", 16'hE010, 32'h0002_0000);
        // R9 collision on each group
        step(1, 16'hF000, 32'hFFFF_FFFF, 32'h0000_0010, 0, 0, 0, 0);
        read_chk("R9 main set wins", 16'hF000, 32'h0000_0010);
        step(1, 16'hE010, 32'hFFFF_FFFF, 0, 16'h0002, 0, 0, 0);
        read_chk("R9 dma set wins", 16'hE010, 32'h0002_0002);
        step(1, 16'hF230, 32'hFFFF_FFFF, 0, 0, 32'h4, 0, 0);
        read_chk("R9 flag set wins", 16'hF230, 32'h4);
        // R10 unmapped write and read
        step(1, 16'hF020, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        read_chk("R10 unmapped read", 16'h1234, 32'h0);
        // R8 flag clear drops irq
        step(1, 16'hF230, 32'h4, 0, 0, 0, 0, 0);
        check("R8 flag_irq low", {31'h0, flag_irq}, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [31:0] d;
            int k = int'($urandom_range(0, 4));
            case (k)
                0: a = 16'hF000;
                1: a = 16'hF010;
                2: a = 16'hE010;
                3: a = 16'hF230;
                default: a = 16'hF004;
            endcase
            d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
            step($urandom_range(0, 1) == 1, a, d,
                 $urandom & $urandom & $urandom,
                 16'($urandom & $urandom & $urandom),
                 $urandom & $urandom & $urandom,
                 $urandom_range(0, 9) == 0, 16'($urandom));
        end

        // R1 reset again clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_main = 0; m_mmask = 0; m_flag = 0; m_dst = 0; m_dmk = 0;
        check_all();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule